// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes stereo PCM from a three-wire audio link: a bit clock, a word (frame) clock and one data line. It runs on a faster system clock and oversamples the two link clocks. One shift engine deserialises the stream in any of five framings: left-aligned MSB-first, I2S, and right-aligned words of 16, 20 or 24 bits. It hands out a registered pair of 24-bit two's-complement samples together with a one-cycle valid strobe.

The effective format is the bitwise OR of a 3-bit programmed field and three strap pins. It is meant to stay fixed while the link runs. A change takes effect cleanly only after a reset. Data bits and the word-clock level are both taken at the rising edge of the bit clock. The word clock must change only while the bit clock is low.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_ni` is low and after its release, `left_o`, `right_o` are zero and `valid_o` is low until the first complete stereo frame has been received.
- R2: Format code 3'b010 (left-aligned): `wclk_i` high marks the left channel, the MSB is the bit taken at the first bit-clock rise after a word-clock change, bits are MSB first in two's complement, and 24 bits are kept.
- R3: In format 3'b010, a channel with fewer than 24 bit-clock periods yields its bits in the upper positions with the missing low bits zero.
- R4: Format code 3'b011 (I2S): `wclk_i` low marks the left channel, the bit at the first rise after a word-clock change is discarded, and the next 24 bits form the sample MSB first.
- R5: Format codes 3'b000, 3'b001 and 3'b100 (right-aligned 16, 20, 24 bits, `wclk_i` high = left): the last N bits before the word-clock change form the sample, sign-extended to 24 bits.
- R6: Format codes 3'b101, 3'b110 and 3'b111 behave exactly as 3'b100.
- R7: The effective format is `fmt_reg_i | fmt_pin_i`.
- R8: `valid_o` pulses for one cycle once per frame, after the right channel has ended. `left_o` and `right_o` change only in that cycle, together. No pulse occurs before a complete left channel has been received since reset.
- R9: Slot bits outside the selected word (padding after a left-aligned or I2S word, bits ahead of a right-aligned word) do not affect the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Link bit clock |
| wclk_i | input | 1 | Link word/frame clock |
| sdata_i | input | 1 | Link serial data |
| fmt_reg_i | input | 3 | Programmed format field |
| fmt_pin_i | input | 3 | Strap-pin format code, ORed with the field |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe: new sample pair present |

## Verification
On every cycle the assertions check the output protocol. The strobe is a single cycle and only follows a detected bit-clock rise. The samples never move outside a strobe. Every 16- and 20-bit right-aligned sample is properly sign-extended. Which bits land where in each framing can only be shown by the bench's scenarios: the left-aligned case with full and short slots, I2S with its discarded first bit, the three right-aligned widths, the aliased codes and the OR of field and pins. These use polarities and padding that would expose a shifted or misplaced word.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  typedef enum logic [2:0] {
    FMT_LSB16 = 3'b000,
    FMT_LSB20 = 3'b001,
    FMT_MSB   = 3'b010,
    FMT_I2S   = 3'b011,
    FMT_LSB24 = 3'b100
  } fmt_e;

  function automatic fmt_e decode_fmt(logic [2:0] code);
    case (code)
      3'b000:  return FMT_LSB16;
      3'b001:  return FMT_LSB20;
      3'b010:  return FMT_MSB;
      3'b011:  return FMT_I2S;
      default: return FMT_LSB24;
    endcase
  endfunction
endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/asrx_edge.sv
module asrx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/asrx_shift.sv
module asrx_shift import asrx_pkg::*; #(
  parameter int DATA_W   = 24,
  parameter int SLOT_MAX = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              ws_i,
  input  logic              d_i,
  input  fmt_e              fmt_i,
  output logic              word_vld_o,
  output logic              word_left_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int CNT_W = $clog2(SLOT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_MAX);

  logic              seen, primed, ws_q;
  logic [CNT_W-1:0]  cnt, idx;
  logic [DATA_W-1:0] acc, sr;
  logic              ws_chg;

  assign ws_chg = seen & (ws_i != ws_q);
  assign idx    = ws_chg ? '0 : cnt;

  function automatic logic [DATA_W-1:0] sext(logic [DATA_W-1:0] v, int n);
    logic signed [DATA_W-1:0] t;
    t = signed'(v << (DATA_W - n));
    return DATA_W'(t >>> (DATA_W - n));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen   <= 1'b0;
      primed <= 1'b0;
      ws_q   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      sr     <= '0;
    end else if (rise_i) begin
      seen   <= 1'b1;
      primed <= primed | ws_chg;
      ws_q   <= ws_i;
      sr     <= {sr[DATA_W-2:0], d_i};
      cnt    <= ws_chg ? CNT_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
      case (fmt_i)
        FMT_MSB: begin
          if (idx == '0)                acc <= DATA_W'(d_i);
          else if (idx < CNT_W'(DATA_W)) acc <= {acc[DATA_W-2:0], d_i};
        end
        FMT_I2S: begin
          // first slot bit belongs to no word
          if (idx == '0)                 acc <= '0;
          else if (idx <= CNT_W'(DATA_W)) acc <= {acc[DATA_W-2:0], d_i};
        end
        default: acc <= acc;
      endcase
    end
  end

  always_comb begin
    int n;
    n = 0;
    case (fmt_i)
      FMT_MSB: begin
        n = (int'(cnt) >= DATA_W) ? DATA_W : int'(cnt);
        word_o = (n == 0) ? '0 : acc << (DATA_W - n);
      end
      FMT_I2S: begin
        n = (cnt == '0) ? 0 : ((int'(cnt) - 1 >= DATA_W) ? DATA_W : int'(cnt) - 1);
        word_o = (n == 0) ? '0 : acc << (DATA_W - n);
      end
      FMT_LSB16: word_o = sext(sr, 16);
      FMT_LSB20: word_o = sext(sr, 20);
      default:   word_o = sr;
    endcase
  end

  assign word_vld_o  = rise_i & ws_chg & primed;
  assign word_left_o = (fmt_i == FMT_I2S) ? ~ws_q : ws_q;
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx import asrx_pkg::*; #(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_MAX    = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic [2:0]        fmt_reg_i,
  input  logic [2:0]        fmt_pin_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic [2:0]        link_s;
  logic              bclk_s, wclk_s, sdata_s;
  logic              bclk_rise;
  fmt_e              fmt;
  logic              word_vld, word_left;
  logic [DATA_W-1:0] word, left_hold;
  logic              have_left;

  asrx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i, .rst_ni, .d_i({bclk_i, wclk_i, sdata_i}), .q_o(link_s)
  );
  assign {bclk_s, wclk_s, sdata_s} = link_s;

  asrx_edge u_edge (.clk_i, .rst_ni, .lvl_i(bclk_s), .rise_o(bclk_rise));

  assign fmt = decode_fmt(fmt_reg_i | fmt_pin_i);

  asrx_shift #(.DATA_W(DATA_W), .SLOT_MAX(SLOT_MAX)) u_shift (
    .clk_i, .rst_ni, .rise_i(bclk_rise), .ws_i(wclk_s), .d_i(sdata_s),
    .fmt_i(fmt), .word_vld_o(word_vld), .word_left_o(word_left), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_vld) begin
        if (word_left) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/asrx_checker.sv
module asrx_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        fmt_reg_i,
  input logic [2:0]        fmt_pin_i,
  input logic              bclk_rise,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o
);
  logic [2:0] eff;
  assign eff = fmt_reg_i | fmt_pin_i;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!valid_o && left_o == '0 && right_o == '0);
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_left_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(left_o) |-> valid_o);

  a_r8_right_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(right_o) |-> valid_o);

  a_r8_after_bclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bclk_rise));

  a_r5_sext16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && eff == 3'b000) |->
      (($countones(left_o[23:15]) == 0) || ($countones(left_o[23:15]) == 9)) &&
      (($countones(right_o[23:15]) == 0) || ($countones(right_o[23:15]) == 9)));

  a_r5_sext20: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && eff == 3'b001) |->
      (($countones(left_o[23:19]) == 0) || ($countones(left_o[23:19]) == 5)) &&
      (($countones(right_o[23:19]) == 0) || ($countones(right_o[23:19]) == 5)));
endmodule

bind audio_serial_rx asrx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fmt_reg_i(fmt_reg_i), .fmt_pin_i(fmt_pin_i),
  .bclk_rise(bclk_rise), .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bclk_i, wclk_i, sdata_i;
  logic [2:0]  fmt_reg_i, fmt_pin_i;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] got_l[$], got_r[$];

  audio_serial_rx dut (.*);

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (valid_o) begin
      got_l.push_back(left_o);
      got_r.push_back(right_o);
    end
  end

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_code(logic [2:0] r, logic [2:0] p);
    int e;
    e = int'(r | p);
    return (e > 4) ? 4 : e;
  endfunction

  function automatic logic [23:0] expect_word(int e, logic [23:0] s, int w);
    case (e)
      0: return {{8{s[15]}}, s[15:0]};
      1: return {{4{s[19]}}, s[19:0]};
      2: return (w >= 24) ? s : ((s >> (24 - w)) << (24 - w));
      default: return s;
    endcase
  endfunction

  function automatic logic slot_bit(int e, logic [23:0] s, int w, int i);
    int n;
    case (e)
      2: return (i < 24) ? s[23-i] : 1'b1;
      3: return (i >= 1 && i <= 24) ? s[24-i] : 1'b1;
      default: begin
        n = (e == 0) ? 16 : ((e == 1) ? 20 : 24);
        return (i >= w - n) ? s[n-1-(i-(w-n))] : 1'b1;
      end
    endcase
  endfunction

  task automatic send_chan(int e, bit left, logic [23:0] s, int w);
    wclk_i = (e == 3) ? ~left : left;
    for (int i = 0; i < w; i++) begin
      sdata_i = slot_bit(e, s, w, i);
      #20 bclk_i = 1'b1;
      #20 bclk_i = 1'b0;
    end
  endtask

  task automatic do_reset(string tag);
    rst_ni = 1'b0;
    bclk_i = 1'b0; wclk_i = 1'b0; sdata_i = 1'b0;
    #20;
    check({tag, " R1 reset"}, {valid_o, 23'd0, left_o | right_o}, 48'd0);
    rst_ni = 1'b1;
    #20;
  endtask

  // one scenario: reset, pre-roll, frames, closing stub, compare
  task automatic run_case(string tag, logic [2:0] r, logic [2:0] p, int w, int seed);
    int e;
    logic [23:0] el[4], er[4];
    fmt_reg_i = r; fmt_pin_i = p;
    e = eff_code(r, p);
    do_reset(tag);
    got_l.delete(); got_r.delete();
    send_chan(e, 1'b0, 24'h5A5A5A, 8);
    for (int k = 0; k < 4; k++) begin
      logic [23:0] l, rr;
      l  = 24'hA5C3E1 + 24'(k * 24'h123457) + 24'(seed);
      rr = ~l ^ 24'(k * 24'h010203);
      if (k == 1) begin l = 24'h7FFFFF; rr = 24'h800000; end
      send_chan(e, 1'b1, l, w);
      send_chan(e, 1'b0, rr, w);
      el[k] = expect_word(e, l, w);
      er[k] = expect_word(e, rr, w);
    end
    send_chan(e, 1'b1, 24'h0, 4);
    #200;
    check({tag, " R8 pulses per frame"}, 48'(got_l.size()), 48'd4);
    for (int k = 0; k < 4 && k < got_l.size(); k++)
      check({tag, " samples"}, {got_l[k], got_r[k]}, {el[k], er[k]});
  endtask

  initial begin
    fork
      begin
        run_case("R5 R9 lsb16",     3'b000, 3'b000, 32, 0);
        run_case("R5 R9 lsb20",     3'b001, 3'b000, 32, 11);
        run_case("R5 R9 lsb24",     3'b100, 3'b000, 32, 22);
        run_case("R2 R9 msb24",     3'b010, 3'b000, 32, 33);
        run_case("R3 msb short16",  3'b010, 3'b000, 16, 44);
        run_case("R3 msb short20",  3'b000, 3'b010, 20, 45);
        run_case("R4 R9 i2s",       3'b011, 3'b000, 32, 55);
        run_case("R6 alias101",     3'b101, 3'b000, 32, 66);
        run_case("R6 alias111",     3'b110, 3'b001, 28, 77);
        run_case("R7 or i2s",       3'b001, 3'b010, 32, 88);
        run_case("R2 msb exact24",  3'b010, 3'b000, 24, 99);
      end
      begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule